// File: doc/BRIEF.md
# Two-Source Destination-Tag Switching Tree

This block joins two request sources to a bank of destination modules through a tree of 2x2 switching elements. Each source offers a valid flag, a destination number and a data word in the same cycle. Every level of the tree reads one bit of the destination number and uses it to pick the upper or lower output of its element. The most significant bit steers the first level and the least significant bit steers the last. With the default of three levels, the tree has eight destination ports, numbered 0 to 7.

The two sources meet only at the first level. When both are valid and their top destination bits match, both want the same output of the first element. In that case source A is passed and source B is blocked. After the first level the two paths never meet again, so no later element can block anything. Each source gets a combinational accept flag in the cycle it presents its request. The flag tells the source whether its request reached its destination.

Each destination port has a registered valid and data pair. These show the routed request one clock edge after it is presented. A blocked or absent request leaves its port untouched.

Top module: `mstage_router`

## Requirements
- R1: A request from either source that is accepted, with destination d (d between 0 and 2^LEVELS-1), sets dst_valid[d] high in the cycle after it is presented. Bit LEVELS-1 of the destination steers the first level and bit 0 steers the last level, so a request to 3 (binary 011) leaves level one on output 0, level two on output 1 and level three on output 1, and arrives on port 3.
- R2: In that cycle, the slice dst_data[d*DATA_W +: DATA_W] holds the data word the source presented with the request.
- R3: When both sources are valid and a_dest and b_dest have equal top bits, source A wins. a_accept is high, b_accept is low, and B's data reaches no port. This includes the case where both sources name the same destination.
- R4: When both sources are valid and their top destination bits differ, both are accepted, and both destinations show their own data in the next cycle.
- R5: a_accept and b_accept are combinational. They reflect the request present in the same cycle, and each is high only for a valid request that reaches its destination.
- R6: A request whose valid flag is low is never accepted, drives no port, and never blocks the other source, even when the two top destination bits match.
- R7: An asynchronous active-low reset clears every dst_valid bit and every dst_data slice to zero.
- R8: A port that receives no accepted request in a cycle shows dst_valid low in the next cycle, and its dst_data slice keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_valid | input | 1 | Source A request present |
| a_dest | input | LEVELS | Source A destination number |
| a_data | input | DATA_W | Source A data word |
| b_valid | input | 1 | Source B request present |
| b_dest | input | LEVELS | Source B destination number |
| b_data | input | DATA_W | Source B data word |
| a_accept | output | 1 | Source A request reaches its destination this cycle |
| b_accept | output | 1 | Source B request reaches its destination this cycle |
| dst_valid | output | 2^LEVELS | Registered per-port valid flags |
| dst_data | output | 2^LEVELS*DATA_W | Registered per-port data words, port d in slice d |

## Verification
A wrong steering bit or a swapped level order sends a word to the wrong port, where it shows on the next clock edge. A fault in the first-level arbitration shows at once on b_accept, or one edge later as two port valids where only one belongs. A lane that loses track of which source it carries puts the other source's data on the right port, so every port's data slice is compared on the cycle after each request. Ports that should hold are checked on that same cycle.

// File: rtl/mstage_router.sv
module mstage_router #(
  parameter int LEVELS = 3,
  parameter int DATA_W = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                a_valid,
  input  logic [LEVELS-1:0]                   a_dest,
  input  logic [DATA_W-1:0]                   a_data,
  input  logic                                b_valid,
  input  logic [LEVELS-1:0]                   b_dest,
  input  logic [DATA_W-1:0]                   b_data,
  output logic                                a_accept,
  output logic                                b_accept,
  output logic [(1<<LEVELS)-1:0]              dst_valid,
  output logic [(1<<LEVELS)*DATA_W-1:0]       dst_data
);
  localparam int NDEST = 1 << LEVELS;
  localparam int LAST  = LEVELS - 1;

  logic lane_v [LEVELS][NDEST];
  logic lane_s [LEVELS][NDEST];

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    for (genvar k = 0; k < NDEST; k++) begin : g_lane
      if (k < (2 << l)) begin : g_used
        localparam int O = k & 1;
        localparam int E = k >> 1;
        logic a_v, a_s, a_hit, b_hit;
        logic [LEVELS-1:0] a_tag;
        if (l == 0) begin : g_root
          assign a_v   = a_valid;
          assign a_s   = 1'b0;
          assign b_hit = b_valid && (b_dest[LEVELS-1] == 1'(O)) && !a_hit;
        end else begin : g_inner
          assign a_v   = lane_v[l-1][E];
          assign a_s   = lane_s[l-1][E];
          assign b_hit = 1'b0;
        end
        assign a_tag = a_s ? b_dest : a_dest;
        assign a_hit = a_v && (a_tag[LEVELS-1-l] == 1'(O));
        assign lane_v[l][k] = a_hit || b_hit;
        assign lane_s[l][k] = b_hit ? 1'b1 : a_s;
      end else begin : g_idle
        assign lane_v[l][k] = 1'b0;
        assign lane_s[l][k] = 1'b0;
      end
    end
  end

  for (genvar k = 0; k < NDEST; k++) begin : g_port
    logic              v_q;
    logic [DATA_W-1:0] d_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        d_q <= '0;
      end else begin
        v_q <= lane_v[LAST][k];
        if (lane_v[LAST][k]) d_q <= lane_s[LAST][k] ? b_data : a_data;
      end
    end
    assign dst_valid[k] = v_q;
    assign dst_data[k*DATA_W +: DATA_W] = d_q;
  end

  assign a_accept = a_valid && lane_v[LAST][a_dest] && !lane_s[LAST][a_dest];
  assign b_accept = b_valid && lane_v[LAST][b_dest] &&  lane_s[LAST][b_dest];
endmodule

// File: rtl/mstage_router_chk.sv
module mstage_router_chk #(
  parameter int LEVELS = 3,
  parameter int DATA_W = 8
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          a_valid,
  input logic [LEVELS-1:0]             a_dest,
  input logic [DATA_W-1:0]             a_data,
  input logic                          b_valid,
  input logic [LEVELS-1:0]             b_dest,
  input logic [DATA_W-1:0]             b_data,
  input logic                          a_accept,
  input logic                          b_accept,
  input logic [(1<<LEVELS)-1:0]        dst_valid,
  input logic [(1<<LEVELS)*DATA_W-1:0] dst_data
);
  assert_a_port_R1: assert property (@(posedge clk) disable iff (!rst_n)
    a_accept |=> dst_valid[$past(a_dest)]);

  assert_b_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    b_accept |=> dst_data[$past(b_dest)*DATA_W +: DATA_W] == $past(b_data));

  assert_a_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    a_accept |=> dst_data[$past(a_dest)*DATA_W +: DATA_W] == $past(a_data));

  assert_conflict_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (a_valid && b_valid && a_dest[LEVELS-1] == b_dest[LEVELS-1]) |-> (a_accept && !b_accept));

  assert_split_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (a_valid && b_valid && a_dest[LEVELS-1] != b_dest[LEVELS-1]) |-> (a_accept && b_accept));

  assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_valid |-> !a_accept) and (!b_valid |-> !b_accept));

  assert_free_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_valid && b_valid) |-> b_accept);

  assert_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $countones(dst_valid) == int'($past(a_accept)) + int'($past(b_accept)));
endmodule

bind mstage_router mstage_router_chk #(.LEVELS(LEVELS), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_mstage_router.sv
module tb_mstage_router;
  localparam int LEVELS = 3;
  localparam int DATA_W = 8;
  localparam int NDEST  = 1 << LEVELS;
  localparam int NVEC   = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_valid = 1'b0, b_valid = 1'b0;
  logic [LEVELS-1:0] a_dest = '0, b_dest = '0;
  logic [DATA_W-1:0] a_data = '0, b_data = '0;
  logic a_accept, b_accept;
  logic [NDEST-1:0] dst_valid;
  logic [NDEST*DATA_W-1:0] dst_data;

  always #5 clk = ~clk;

  mstage_router #(.LEVELS(LEVELS), .DATA_W(DATA_W)) dut (.*);

  // {a_valid, a_dest, a_data, b_valid, b_dest, b_data, exp_a_accept, exp_b_accept}
  localparam logic [25:0] VEC [NVEC] = '{
    {1'b1, 3'd5, 8'h11, 1'b0, 3'd0, 8'h00, 1'b1, 1'b0},
    {1'b0, 3'd0, 8'h00, 1'b1, 3'd3, 8'h22, 1'b0, 1'b1},
    {1'b1, 3'd1, 8'h33, 1'b1, 3'd6, 8'h44, 1'b1, 1'b1},
    {1'b1, 3'd2, 8'h55, 1'b1, 3'd0, 8'h66, 1'b1, 1'b0},
    {1'b1, 3'd7, 8'h77, 1'b1, 3'd7, 8'h88, 1'b1, 1'b0},
    {1'b1, 3'd4, 8'h99, 1'b1, 3'd5, 8'hAA, 1'b1, 1'b0},
    {1'b0, 3'd6, 8'hBB, 1'b1, 3'd7, 8'hCC, 1'b0, 1'b1},
    {1'b0, 3'd1, 8'h12, 1'b0, 3'd2, 8'h34, 1'b0, 1'b0},
    {1'b1, 3'd6, 8'hDD, 1'b1, 3'd1, 8'hEE, 1'b1, 1'b1},
    {1'b1, 3'd3, 8'hF0, 1'b0, 3'd3, 8'h0F, 1'b1, 1'b0},
    {1'b1, 3'd0, 8'h5A, 1'b1, 3'd4, 8'hA5, 1'b1, 1'b1}
  };

  int tests = 0, fails = 0;
  bit done = 1'b0;
  logic [DATA_W-1:0] shadow [NDEST];

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_ports(input logic [NDEST-1:0] exp_v, input string req);
    logic [NDEST*DATA_W-1:0] exp_d;
    for (int k = 0; k < NDEST; k++) exp_d[k*DATA_W +: DATA_W] = shadow[k];
    check(dst_valid == exp_v, {req, " valid"}, 64'(dst_valid), 64'(exp_v));
    check(dst_data == exp_d, {req, " data"}, 64'(dst_data), 64'(exp_d));
  endtask

  task automatic run_vec(input logic [25:0] v, input string req);
    logic [NDEST-1:0] exp_v;
    a_valid = v[25]; a_dest = v[24:22]; a_data = v[21:14];
    b_valid = v[13]; b_dest = v[12:10]; b_data = v[9:2];
    #1;
    check(a_accept == v[1], {req, " a_accept R5"}, 64'(a_accept), 64'(v[1]));
    check(b_accept == v[0], {req, " b_accept R5"}, 64'(b_accept), 64'(v[0]));
    exp_v = '0;
    if (v[1]) begin exp_v[v[24:22]] = 1'b1; shadow[v[24:22]] = v[21:14]; end
    if (v[0]) begin exp_v[v[12:10]] = 1'b1; shadow[v[12:10]] = v[9:2]; end
    @(negedge clk);
    check_ports(exp_v, {req, " R1 R2 R8"});
  endtask

  initial begin
    for (int k = 0; k < NDEST; k++) shadow[k] = '0;
    repeat (2) @(negedge clk);
    check_ports('0, "R7 reset");
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NVEC; i++) run_vec(VEC[i], $sformatf("vec%0d", i));

    // R1: route 011 lands on port 3 only, from source B alone
    run_vec({1'b0, 3'd0, 8'h00, 1'b1, 3'd3, 8'hC3, 1'b0, 1'b1}, "R1 route 011");
    // R3: same destination, A wins, B data appears nowhere
    run_vec({1'b1, 3'd2, 8'h61, 1'b1, 3'd2, 8'h62, 1'b1, 1'b0}, "R3 same dest");
    // R4: both MSB halves used at once
    run_vec({1'b1, 3'd7, 8'h71, 1'b1, 3'd0, 8'h70, 1'b1, 1'b1}, "R4 split");
    // R6: idle A with matching MSB does not block B
    run_vec({1'b0, 3'd5, 8'h99, 1'b1, 3'd4, 8'h44, 1'b0, 1'b1}, "R6 idle A");
    // R8: idle cycle, every port holds
    run_vec({1'b0, 3'd0, 8'h00, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0}, "R8 hold");

    // R7: mid-run reset clears ports
    a_valid = 1'b1; a_dest = 3'd6; a_data = 8'hE6; b_valid = 1'b0;
    @(negedge clk);
    a_valid = 1'b0;
    #2 rst_n = 1'b0;
    #1;
    for (int k = 0; k < NDEST; k++) shadow[k] = '0;
    check_ports('0, "R7 mid reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_ports('0, "R7 after reset");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule